// File: doc/BRIEF.md
# Shared test-pin mode controller

This block decides, cycle by cycle, whether three pads serve user logic or the boundary-scan test port. The pads are the test data input, the test clock and the test data output. A configuration bit picks one of two modes. In the first, the three pads are held as test pins for good. In the second, which is the unprogrammed default, the pads start as user I/O and are claimed by the test port only when the test clock rises while the mode-select line is low. They are handed back to user logic as soon as the TAP controller reaches Test-Logic-Reset.

The mode-select pad is always a test input and is never offered to user logic. An optional reset pad can serve as an asynchronous TAP reset, or it can be given to user logic with its pull-up turned off. The whole block runs on a fast system clock. The test clock, mode-select and test data inputs are sampled through two-stage synchronisers, and test clock edges are found in the system-clock domain. A complete 16-state TAP controller drives the return to user I/O. It has a 2-bit instruction register and a 1-bit bypass register.

Top module: `pad_share_ctrl`

## Requirements
- R1: After rst_n, in flexible mode (cfg_dedicated=0), the TAP is in Test-Logic-Reset and all three shared pads are in user mode. For each pad index i (bit 0 test data in, bit 1 test clock, bit 2 test data out), pad_oe[i] equals usr_oe[i], pad_out[i] equals usr_out[i], and usr_in[i] equals pad_in[i].
- R2: With cfg_dedicated=1 the pads are test pins whatever the TAP state. pad_oe[1:0] and pad_out[1:0] are 0, usr_in is 3'b000, and usr_oe and usr_out have no effect.
- R3: In flexible mode, a rising edge of the synchronised test clock sampled while the synchronised mode-select is low switches the pads to test use. The pads show test behaviour from the third system-clock edge after the pad inputs change.
- R4: Test clock rising edges sampled with mode-select high while the TAP is in Test-Logic-Reset leave the pads in user mode.
- R5: In flexible mode, the pads return to user mode one system clock after the TAP enters Test-Logic-Reset.
- R6: Five consecutive test clock rising edges with mode-select high bring the TAP to Test-Logic-Reset from any state. After only four such edges from Shift-DR, the pads are still in test use.
- R7: In test use, pad_oe[2] is 1 only after a falling test clock edge seen in Shift-DR or Shift-IR, and returns to 0 at the first falling edge seen in any other state. pad_out[2] changes only on falling edges.
- R8: Capture-IR loads binary 01 into the instruction register. Shift-IR shifts it out least significant bit first on pad_out[2], with the test data input entering at the most significant end.
- R9: Every instruction code selects the 1-bit bypass register. Capture-DR loads it with 0, and in Shift-DR pad_out[2] repeats the test data input sampled at the previous rising edge.
- R10: With trst_en=1, trst_pad_in low resets the TAP asynchronously, so the pads return to user mode one clock later. In this mode trst_pu=1, trst_pad_oe=0, trst_pad_out=0 and usr_trst_in=0. With trst_en=0 the reset pad is user I/O: trst_pu=0, trst_pad_oe equals usr_trst_oe, trst_pad_out equals usr_trst_out, and usr_trst_in equals trst_pad_in. A low level on the pad then has no effect on the TAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pads |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dedicated | input | 1 | 1 = pads are permanently test pins, 0 = flexible sharing |
| trst_en | input | 1 | 1 = reset pad is an asynchronous TAP reset |
| pad_tms | input | 1 | Mode-select pad input |
| pad_in | input | 3 | Shared pad inputs (0 data in, 1 clock, 2 data out) |
| pad_oe | output | 3 | Shared pad output enables |
| pad_out | output | 3 | Shared pad output data |
| usr_oe | input | 3 | User output enables for the shared pads |
| usr_out | input | 3 | User output data for the shared pads |
| usr_in | output | 3 | Shared pad inputs forwarded to user logic |
| trst_pad_in | input | 1 | Reset pad input |
| trst_pad_oe | output | 1 | Reset pad output enable |
| trst_pad_out | output | 1 | Reset pad output data |
| trst_pu | output | 1 | Reset pad pull-up enable |
| usr_trst_oe | input | 1 | User output enable for the reset pad |
| usr_trst_out | input | 1 | User output data for the reset pad |
| usr_trst_in | output | 1 | Reset pad input forwarded to user logic |

## Verification
The hardest case to reach is the release boundary. The bench drives the TAP deep into the data branch and then counts mode-select-high edges. It checks that the fourth edge still leaves the pads claimed and that the fifth hands them back one system clock later. The instruction and bypass paths show up only on the data-output pad, and only after falling edges. The stimulus therefore walks the exact mode-select sequence into Shift-IR and Shift-DR with chosen data bits, and a behavioural TAP model in the bench predicts every pad on every clock. The asynchronous reset pad is pulled mid-test both with the reset function enabled and with it disabled, to show that it acts only in the first case.

// File: rtl/pad_share_pkg.sv
package pad_share_pkg;
  localparam int PAD_NUM = 3;
  localparam int PAD_TDI = 0;
  localparam int PAD_TCK = 1;
  localparam int PAD_TDO = 2;
  localparam int IR_W    = 2;
  localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR,
    ST_EX2_DR, ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR,
    ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  function automatic tap_st_e f_tap_next(tap_st_e s, logic tms);
    tap_st_e n;
    case (s)
      ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      default:   n = tms ? ST_SEL_DR : ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic f_is_shift(tap_st_e s);
    return (s == ST_SH_DR) || (s == ST_SH_IR);
  endfunction
endpackage

// File: rtl/pad_share_sync.sv
module pad_share_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pad_share_tap.sv
module pad_share_tap
  import pad_share_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic    clk,
  input  logic    tap_rst_n,
  input  logic    tck_rise,
  input  logic    tck_fall,
  input  logic    tms,
  input  logic    tdi,
  output tap_st_e state,
  output logic    tdo,
  output logic    tdo_oe
);
  localparam int RUN_W = $clog2(RESET_RUN + 1);

  logic [IR_W-1:0] ir_sh;
  logic            byp;

  always_ff @(posedge clk or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      state <= ST_RESET;
      ir_sh <= '0;
      byp   <= 1'b0;
    end else if (tck_rise) begin
      if (state == ST_CAP_IR)     ir_sh <= IR_CAPTURE;
      else if (state == ST_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (state == ST_CAP_DR)     byp <= 1'b0;
      else if (state == ST_SH_DR) byp <= tdi;
      state <= f_tap_next(state, tms);
    end
  end

  always_ff @(posedge clk or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (tck_fall) begin
      tdo_oe <= f_is_shift(state);
      if (state == ST_SH_IR)      tdo <= ir_sh[0];
      else if (state == ST_SH_DR) tdo <= byp;
    end
  end

  // checker aid: run length of mode-select-high rising edges
  logic [RUN_W-1:0] hi_run;
  always_ff @(posedge clk or negedge tap_rst_n) begin
    if (!tap_rst_n) hi_run <= '0;
    else if (tck_rise) begin
      if (!tms)                        hi_run <= '0;
      else if (hi_run != RUN_W'(RESET_RUN)) hi_run <= hi_run + 1'b1;
    end
  end

  assert_reset_run_R6: assert property (@(posedge clk) disable iff (!tap_rst_n)
    (hi_run == RUN_W'(RESET_RUN)) |-> (state == ST_RESET));

  assert_tdo_on_fall_R7: assert property (@(posedge clk) disable iff (!tap_rst_n)
    $rose(tdo_oe) |-> $past(tck_fall));

  assert_tdo_window_R7: assert property (@(posedge clk) disable iff (!tap_rst_n)
    tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR ||
                state == ST_EX1_DR || state == ST_EX1_IR));
endmodule

// File: rtl/pad_share_mux.sv
module pad_share_mux
  import pad_share_pkg::*;
#(
  parameter int NPADS = PAD_NUM
) (
  input  logic             in_test,
  input  logic             tdo,
  input  logic             tdo_oe,
  input  logic [NPADS-1:0] usr_oe,
  input  logic [NPADS-1:0] usr_out,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_oe,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] usr_in
);
  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    logic t_oe, t_out;
    if (i == PAD_TDO) begin : g_drv
      assign t_oe  = tdo_oe;
      assign t_out = tdo;
    end else begin : g_rcv
      assign t_oe  = 1'b0;
      assign t_out = 1'b0;
    end
    assign pad_oe[i]  = in_test ? t_oe  : usr_oe[i];
    assign pad_out[i] = in_test ? t_out : usr_out[i];
    assign usr_in[i]  = in_test ? 1'b0  : pad_in[i];
  end
endmodule

// File: rtl/pad_share_ctrl.sv
module pad_share_ctrl
  import pad_share_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_RUN   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_dedicated,
  input  logic               trst_en,
  input  logic               pad_tms,
  input  logic [PAD_NUM-1:0] pad_in,
  output logic [PAD_NUM-1:0] pad_oe,
  output logic [PAD_NUM-1:0] pad_out,
  input  logic [PAD_NUM-1:0] usr_oe,
  input  logic [PAD_NUM-1:0] usr_out,
  output logic [PAD_NUM-1:0] usr_in,
  input  logic               trst_pad_in,
  output logic               trst_pad_oe,
  output logic               trst_pad_out,
  output logic               trst_pu,
  input  logic               usr_trst_oe,
  input  logic               usr_trst_out,
  output logic               usr_trst_in
);
  localparam int SW = 3;

  logic [SW-1:0] sync_q;
  logic          tck_s, tdi_s, tms_s, tck_prev;
  logic          tck_rise, tck_fall, entry_seen;
  logic          trst_act, tap_rst_n;
  logic          test_use_q, in_test;
  logic          tdo, tdo_oe;
  tap_st_e       tap_state;

  pad_share_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pad_tms, pad_in[PAD_TDI], pad_in[PAD_TCK]}),
    .q(sync_q)
  );
  assign tck_s = sync_q[0];
  assign tdi_s = sync_q[1];
  assign tms_s = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tck_prev <= 1'b0;
    else        tck_prev <= tck_s;
  end
  assign tck_rise   = tck_s & ~tck_prev;
  assign tck_fall   = ~tck_s & tck_prev;
  assign entry_seen = tck_rise & ~tms_s;

  assign trst_act  = trst_en & ~trst_pad_in;
  assign tap_rst_n = rst_n & ~trst_act;

  pad_share_tap #(.RESET_RUN(RESET_RUN)) u_tap (
    .clk(clk), .tap_rst_n(tap_rst_n), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .tms(tms_s), .tdi(tdi_s), .state(tap_state), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       test_use_q <= 1'b0;
    else if (entry_seen)              test_use_q <= 1'b1;
    else if (tap_state == ST_RESET)   test_use_q <= 1'b0;
  end
  assign in_test = cfg_dedicated | test_use_q;

  pad_share_mux #(.NPADS(PAD_NUM)) u_mux (
    .in_test(in_test), .tdo(tdo), .tdo_oe(tdo_oe),
    .usr_oe(usr_oe), .usr_out(usr_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .usr_in(usr_in)
  );

  assign trst_pu      = trst_en;
  assign trst_pad_oe  = trst_en ? 1'b0 : usr_trst_oe;
  assign trst_pad_out = trst_en ? 1'b0 : usr_trst_out;
  assign usr_trst_in  = trst_en ? 1'b0 : trst_pad_in;

  assert_entry_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_use_q) |-> $past(entry_seen));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_state == ST_RESET && !entry_seen) |=> !test_use_q);

  assert_trst_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trst_act |-> (tap_state == ST_RESET));
endmodule

// File: tb/test_pad_share_ctrl.sv
module test_pad_share_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dedicated = 1'b0, trst_en = 1'b0, pad_tms = 1'b1;
  logic [2:0] pad_in = 3'b000, usr_oe = 3'b000, usr_out = 3'b000;
  logic trst_pad_in = 1'b1, usr_trst_oe = 1'b0, usr_trst_out = 1'b0;
  logic [2:0] pad_oe, pad_out, usr_in;
  logic trst_pad_oe, trst_pad_out, trst_pu, usr_trst_in;

  pad_share_ctrl i_pad_share_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_dedicated(cfg_dedicated), .trst_en(trst_en),
    .pad_tms(pad_tms), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .usr_oe(usr_oe), .usr_out(usr_out), .usr_in(usr_in),
    .trst_pad_in(trst_pad_in), .trst_pad_oe(trst_pad_oe), .trst_pad_out(trst_pad_out),
    .trst_pu(trst_pu), .usr_trst_oe(usr_trst_oe), .usr_trst_out(usr_trst_out),
    .usr_trst_in(usr_trst_in)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // behavioural reference: TAP states as integers
  localparam int S_TLR = 0, S_RTI = 1, S_SDS = 2, S_CDR = 3, S_SDR = 4, S_E1D = 5,
                 S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIS = 9, S_CIR = 10, S_SIR = 11,
                 S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;
  int  m_st = S_TLR;
  bit  m_tu = 0, m_tdo = 0, m_toe = 0, m_byp = 0;
  bit [1:0] m_ir = 2'b00;
  bit  c1 = 0, c2 = 0, c3 = 0, ms1 = 0, ms2 = 0, ds1 = 0, ds2 = 0;
  bit  rise, fall, ntu;

  function automatic int nxt(int s, bit tms);
    int hi [16] = '{S_TLR, S_SDS, S_SIS, S_E1D, S_E1D, S_UDR, S_E2D, S_UDR,
                    S_SDS, S_TLR, S_E1I, S_E1I, S_UIR, S_E2I, S_UIR, S_SDS};
    int lo [16] = '{S_RTI, S_RTI, S_CDR, S_SDR, S_SDR, S_PDR, S_PDR, S_SDR,
                    S_RTI, S_CIR, S_SIR, S_SIR, S_PIR, S_PIR, S_SIR, S_RTI};
    return tms ? hi[s] : lo[s];
  endfunction

  task automatic tap_clear();
    m_st = S_TLR; m_ir = 2'b00; m_byp = 0; m_tdo = 0; m_toe = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      tap_clear(); m_tu = 0;
      c1 = 0; c2 = 0; c3 = 0; ms1 = 0; ms2 = 0; ds1 = 0; ds2 = 0;
    end else begin
      rise = c2 && !c3;
      fall = !c2 && c3;
      ntu = m_tu;
      if (rise && !ms2) ntu = 1;
      else if (m_st == S_TLR) ntu = 0;
      if (trst_en && !trst_pad_in) tap_clear();
      else begin
        if (rise) begin
          if (m_st == S_CIR) m_ir = 2'b01;
          else if (m_st == S_SIR) m_ir = {ds2, m_ir[1]};
          if (m_st == S_CDR) m_byp = 0;
          else if (m_st == S_SDR) m_byp = ds2;
          m_st = nxt(m_st, ms2);
        end
        if (fall) begin
          m_toe = (m_st == S_SIR) || (m_st == S_SDR);
          if (m_st == S_SIR) m_tdo = m_ir[0];
          else if (m_st == S_SDR) m_tdo = m_byp;
        end
      end
      m_tu = ntu;
      c3 = c2; c2 = c1; c1 = pad_in[1];
      ms2 = ms1; ms1 = pad_tms;
      ds2 = ds1; ds1 = pad_in[0];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    bit in_t;
    logic [2:0] e_oe, e_out, e_in;
    if (!done) begin
      if (rst_n && trst_en && !trst_pad_in) tap_clear();
      in_t = cfg_dedicated || m_tu;
      e_oe  = in_t ? {m_toe, 2'b00} : usr_oe;
      e_out = in_t ? {m_tdo, 2'b00} : usr_out;
      e_in  = in_t ? 3'b000 : pad_in;
      chk("R3 shared pads", {pad_oe[1:0], pad_out[1:0], usr_in},
          {e_oe[1:0], e_out[1:0], e_in});
      chk("R7 data-out pad", {pad_oe[2], (pad_oe[2] ? pad_out[2] : 1'b0)},
          {e_oe[2], (e_oe[2] ? e_out[2] : 1'b0)});
      chk("R10 reset pad", {trst_pad_oe, trst_pad_out, trst_pu, usr_trst_in},
          trst_en ? 4'b0010 : {usr_trst_oe, usr_trst_out, 1'b0, trst_pad_in});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #5; end
  endtask

  task automatic pulse(input bit tms, input bit tdi);
    pad_tms = tms; pad_in[0] = tdi; pad_in[1] = 1'b0;
    step(4);
    pad_in[1] = 1'b1;
    step(4);
    pad_in[1] = 1'b0;
    step(4);
  endtask

  initial begin
    usr_oe = 3'b101; usr_out = 3'b011; pad_in = 3'b100;
    step(3);
    rst_n = 1'b1;
    step(3);
    // R1 reset state
    chk("R1 oe after reset", pad_oe, 3'b101);
    chk("R1 out after reset", pad_out, 3'b011);
    chk("R1 in after reset", usr_in, 3'b100);

    // R4 edges with TMS high in reset stay user
    for (int j = 0; j < 3; j++) pulse(1, 1);
    pad_in[2] = 1'b1;
    step(1);
    chk("R4 still user", usr_in[2], 1);

    // R3 entry: TMS low then watch the exact latency
    pad_tms = 0; pad_in[1] = 1'b0; step(4);
    pad_in[1] = 1'b1;
    step(2);
    chk("R3 not yet after two edges", usr_in[2], 1);
    step(1);
    chk("R3 claimed at third edge", usr_in, 3'b000);
    chk("R3 clock/data-in pads undriven", pad_oe[1:0], 2'b00);
    pad_in[1] = 1'b0; step(4);   // now in Run-Test/Idle

    // R8 into Shift-IR
    pulse(1, 0); pulse(1, 0); pulse(0, 0); pulse(0, 0);
    chk("R8 capture bit0 driven", {pad_oe[2], pad_out[2]}, 2'b11);
    pulse(0, 1);
    chk("R8 capture bit1", pad_out[2], 0);
    pulse(0, 0);
    chk("R8 shifted-in bit appears", pad_out[2], 1);
    pulse(1, 0);                  // Exit1-IR
    chk("R7 released outside shift", pad_oe[2], 0);

    // R9 Update-IR, Select-DR, Capture-DR, Shift-DR
    pulse(1, 0); pulse(1, 0); pulse(0, 0); pulse(0, 0);
    chk("R9 bypass capture zero", {pad_oe[2], pad_out[2]}, 2'b10);
    pulse(0, 1);
    chk("R9 bypass one", pad_out[2], 1);
    pulse(0, 0);
    chk("R9 bypass zero", pad_out[2], 0);
    pulse(0, 1);
    chk("R9 bypass one again", pad_out[2], 1);

    // R6 four high edges still claimed, fifth releases (R5)
    for (int j = 0; j < 4; j++) pulse(1, 0);
    chk("R6 four edges keep test use", usr_in, 3'b000);
    pulse(1, 0);
    chk("R5 pads back to user", usr_in, 3'b100);
    chk("R5 oe back to user", pad_oe, 3'b101);

    // R2 dedicated mode
    cfg_dedicated = 1'b1; usr_oe = 3'b111; usr_out = 3'b111;
    step(2);
    chk("R2 dedicated oe", pad_oe, 3'b000);
    chk("R2 dedicated in", usr_in, 3'b000);
    for (int j = 0; j < 5; j++) pulse(1, 0);
    chk("R2 dedicated after reset state", pad_oe[1:0], 2'b00);
    cfg_dedicated = 1'b0;
    step(2);
    chk("R1 flexible restored", pad_oe, 3'b111);

    // R10 reset pad enabled
    trst_en = 1'b1;
    step(1);
    chk("R10 pull-up on", trst_pu, 1);
    pulse(0, 0); pulse(1, 0); pulse(0, 0); pulse(0, 0);   // Shift-DR
    chk("R10 in test before reset", usr_in, 3'b000);
    trst_pad_in = 1'b0;
    step(2);
    chk("R10 reset pad releases pads", usr_in, 3'b100);
    trst_pad_in = 1'b1;
    step(2);

    // R10 reset pad disabled has no effect
    trst_en = 1'b0; usr_trst_oe = 1'b1; usr_trst_out = 1'b1;
    step(1);
    chk("R10 user reset pad", {trst_pu, trst_pad_oe, trst_pad_out}, 3'b011);
    pulse(0, 0);
    trst_pad_in = 1'b0;
    step(3);
    chk("R10 disabled reset ignored", usr_in, 3'b000);
    chk("R10 pad input forwarded", usr_trst_in, 0);
    trst_pad_in = 1'b1;
    for (int j = 0; j < 5; j++) pulse(1, 0);
    chk("R5 final release", usr_in, 3'b100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule